// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port that sits on a simple memory-mapped register bus. Software sets an output value and a per-pin drive enable, and reads back the synchronised level of every pad. Each pin also has an event detector. The detector can watch for a low level, a high level, a rising edge, a falling edge, or any change.

Detected events set bits in a sticky status register. Software clears those bits by writing ones. A mask register selects which pending bits reach the interrupt lines. There is one line for pins 0–15, one for pins 16–31, and one combined line.

A bus access takes a single cycle. `bus_sel` with `bus_we` high writes `bus_wdata` at the rising clock edge. `bus_sel` with `bus_we` low returns the addressed register on `bus_rdata` in the same cycle. Pad inputs pass through two synchronising flops before detection. Edge detection compares the synchronised value with its value one cycle earlier.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, every register reads 0, `pad_oe` is 0 and all three interrupt outputs are 0.
- R2: `pad_out` equals the output-data register. `pad_oe` bit n is 1 exactly when direction bit n is 1 (1 = drive, 0 = input). A write takes effect on the edge that accepts it.
- R3: Word offsets are: 0x00 output data, 0x04 direction, 0x08 pad level (read-only, writes ignored), 0x0C trigger codes for pins 0–15, 0x10 trigger codes for pins 16–31, 0x14 mask, 0x18 status, 0x1C any-change select. Address bits 1:0 are ignored. `bus_rdata` is 0 when no read is in progress.
- R4: Offset 0x08 returns each pad's level after two synchronising flops, whatever the pin's direction. A pad change is readable after the second rising edge.
- R5: Pin n's trigger code is 2 bits wide, at bit 2·(n mod 16). It sits in the low code register for n < 16 and in the high code register otherwise.
- R6: Code 00 (low level) and code 01 (high level) set the status bit on every cycle the level holds. Clearing the bit while the level persists has no lasting effect.
- R7: Code 10 flags a rising edge and code 11 flags a falling edge, once per edge. After a pad change, the status bit is readable after the third rising edge and not before.
- R8: When a pin's any-change bit is 1, the pin flags both rising and falling edges, and its trigger code is ignored.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R10: `irq_lo` is high when any of pins 0–15 has both its status bit and its mask bit set (mask 1 = enabled). `irq_hi` is the same for pins 16–31. `irq_any` is their OR.
- R11: Status bits latch whether or not the pin is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Per-pin drive enable |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |
| irq_any | output | 1 | OR of both interrupt lines |

## Verification
The hardest situations to reach from the ports are collisions: a clear write landing while a level trigger is still active, and an any-change bit overriding a trigger code that would have behaved differently. The stimulus holds a pad at its triggering level across a clear write and reads the status back at once. It also pairs the any-change bit with a rising-only code and then drives a falling edge. Finally, it pairs the any-change bit with a low-level code while the pad stays low, so the override shows up as an absent event. A behavioural model runs alongside the design and compares every output on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_IDX_W  = 3;
    localparam int BYTE_OFS_W = 2;
    localparam int BUS_ADDR_W = REG_IDX_W + BYTE_OFS_W;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_DATA   = 3'd0,
        IDX_DIR    = 3'd1,
        IDX_PAD    = 3'd2,
        IDX_CFG_LO = 3'd3,
        IDX_CFG_HI = 3'd4,
        IDX_MASK   = 3'd5,
        IDX_STAT   = 3'd6,
        IDX_ANY    = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // two flops against metastability, a third for edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic  sync_i,
    input  logic  prev_i,
    input  trig_e code_i,
    input  logic  any_i,
    output logic  evt_o
);

    always_comb begin
        evt_o = 1'b0;
        if (any_i) begin
            evt_o = sync_i ^ prev_i;
        end else begin
            unique case (code_i)
                TRIG_LOW:  evt_o = ~sync_i;
                TRIG_HIGH: evt_o = sync_i;
                TRIG_RISE: evt_o = sync_i & ~prev_i;
                TRIG_FALL: evt_o = ~sync_i & prev_i;
            endcase
        end
    end

endmodule

// File: rtl/gpio_csr.sv
module gpio_csr
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  reg_idx_e        idx_i,
    input  logic [PINS-1:0] wdata_i,
    output logic [PINS-1:0] rdata_o,
    input  logic [PINS-1:0] pad_sync_i,
    input  logic [PINS-1:0] evt_i,
    output logic [PINS-1:0] data_o,
    output logic [PINS-1:0] dir_o,
    output logic [PINS-1:0] cfg_lo_o,
    output logic [PINS-1:0] cfg_hi_o,
    output logic [PINS-1:0] mask_o,
    output logic [PINS-1:0] stat_o,
    output logic [PINS-1:0] any_o
);

    logic            wr;
    logic [PINS-1:0] clr_vec;
    logic [PINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q, any_q;

    assign wr      = bus_sel & bus_we;
    assign clr_vec = (wr && idx_i == IDX_STAT) ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            any_q    <= '0;
        end else if (wr) begin
            unique case (idx_i)
                IDX_DATA:   data_q   <= wdata_i;
                IDX_DIR:    dir_q    <= wdata_i;
                IDX_PAD:    ;
                IDX_CFG_LO: cfg_lo_q <= wdata_i;
                IDX_CFG_HI: cfg_hi_q <= wdata_i;
                IDX_MASK:   mask_q   <= wdata_i;
                IDX_STAT:   ;
                IDX_ANY:    any_q    <= wdata_i;
            endcase
        end
    end

    // a fresh event outranks a write-one clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | evt_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (bus_sel && !bus_we) begin
            unique case (idx_i)
                IDX_DATA:   rdata_o = data_q;
                IDX_DIR:    rdata_o = dir_q;
                IDX_PAD:    rdata_o = pad_sync_i;
                IDX_CFG_LO: rdata_o = cfg_lo_q;
                IDX_CFG_HI: rdata_o = cfg_hi_q;
                IDX_MASK:   rdata_o = mask_q;
                IDX_STAT:   rdata_o = stat_q;
                IDX_ANY:    rdata_o = any_q;
            endcase
        end
    end

    assign data_o   = data_q;
    assign dir_o    = dir_q;
    assign cfg_lo_o = cfg_lo_q;
    assign cfg_hi_o = cfg_hi_q;
    assign mask_o   = mask_q;
    assign stat_o   = stat_q;
    assign any_o    = any_q;

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx_i == IDX_DIR) |=> (dir_q == $past(wdata_i))); // R2
    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx_i == IDX_DATA) |=> (data_q == $past(wdata_i))); // R2
    AST_STAT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && idx_i == IDX_STAT) |=> (($past(stat_q) & ~stat_q) == '0)); // R9
    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R11

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]       bus_wdata,
    output logic [PINS-1:0]       bus_rdata,
    input  logic [PINS-1:0]       pad_in,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe,
    output logic                  irq_lo,
    output logic                  irq_hi,
    output logic                  irq_any
);

    localparam int HALF = PINS / 2;

    reg_idx_e        idx;
    logic [PINS-1:0] pad_sync, pad_prev, evt;
    logic [PINS-1:0] cfg_lo, cfg_hi, mask, stat, any_sel;
    logic [PINS-1:0] pend;
    wire             unused_byte_ofs = ^bus_addr[BYTE_OFS_W-1:0];

    assign idx = reg_idx_e'(bus_addr[BYTE_OFS_W +: REG_IDX_W]);

    gpio_pad_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in),
        .sync_o (pad_sync),
        .prev_o (pad_prev)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        trig_e code;
        if (g < HALF) begin : g_lo
            assign code = trig_e'(cfg_lo[2*g +: 2]);
        end else begin : g_hi
            assign code = trig_e'(cfg_hi[2*(g-HALF) +: 2]);
        end
        gpio_pin_detect u_det (
            .sync_i (pad_sync[g]),
            .prev_i (pad_prev[g]),
            .code_i (code),
            .any_i  (any_sel[g]),
            .evt_o  (evt[g])
        );
    end

    gpio_csr #(.PINS(PINS)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .idx_i      (idx),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .pad_sync_i (pad_sync),
        .evt_i      (evt),
        .data_o     (pad_out),
        .dir_o      (pad_oe),
        .cfg_lo_o   (cfg_lo),
        .cfg_hi_o   (cfg_hi),
        .mask_o     (mask),
        .stat_o     (stat),
        .any_o      (any_sel)
    );

    assign pend    = stat & mask;
    assign irq_lo  = |pend[HALF-1:0];
    assign irq_hi  = |pend[PINS-1:HALF];
    assign irq_any = irq_lo | irq_hi;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_any); // R10
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> !(irq_lo || irq_hi)); // R10

endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q = CLK_PERIOD / 4;

    localparam logic [2:0] A_DATA = 3'd0, A_DIR = 3'd1, A_PAD = 3'd2, A_LO = 3'd3,
                           A_HI = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_ANY = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi, irq_any;

    integer n_tests = 0;
    integer n_fail = 0;
    logic   cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    // behavioural reference
    logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [31:0] m_data = '0, m_dir = '0, m_lo = '0, m_hi = '0;
    logic [31:0] m_mask = '0, m_stat = '0, m_any = '0;

    function automatic logic [31:0] model_evt(input logic [31:0] s, input logic [31:0] p);
        logic [31:0] e;
        logic [1:0]  c;
        e = '0;
        for (int i = 0; i < 32; i++) begin
            c = (i < 16) ? m_lo[2*i +: 2] : m_hi[2*(i-16) +: 2];
            if (m_any[i]) e[i] = s[i] != p[i];
            else if (c == 2'b00) e[i] = !s[i];
            else if (c == 2'b01) e[i] = s[i];
            else if (c == 2'b10) e[i] = s[i] && !p[i];
            else e[i] = !s[i] && p[i];
        end
        return e;
    endfunction

    function automatic logic [31:0] model_rd();
        if (!(bus_sel && !bus_we)) return '0;
        case (bus_addr[4:2])
            A_DATA: return m_data;
            A_DIR:  return m_dir;
            A_PAD:  return m_s2;
            A_LO:   return m_lo;
            A_HI:   return m_hi;
            A_MASK: return m_mask;
            A_STAT: return m_stat;
            default: return m_any;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_data = '0; m_dir = '0;
            m_lo = '0; m_hi = '0; m_mask = '0; m_stat = '0; m_any = '0;
        end else begin
            logic [31:0] e;
            e = model_evt(m_s2, m_prev);
            if (bus_sel && bus_we) begin
                case (bus_addr[4:2])
                    A_DATA: m_data = bus_wdata;
                    A_DIR:  m_dir  = bus_wdata;
                    A_LO:   m_lo   = bus_wdata;
                    A_HI:   m_hi   = bus_wdata;
                    A_MASK: m_mask = bus_wdata;
                    A_STAT: m_stat = m_stat & ~bus_wdata;
                    A_ANY:  m_any  = bus_wdata;
                    default: ;
                endcase
            end
            m_stat = m_stat | e;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #(Q);
        if (rst_n && cmp_en) begin
            check(pad_out, m_data, "R2 pad_out vs model");
            check(pad_oe, m_dir, "R2 pad_oe vs model");
            check(bus_rdata, model_rd(), "R3 rdata vs model");
            check({31'd0, irq_lo}, {31'd0, |(m_stat[15:0] & m_mask[15:0])}, "R10 irq_lo vs model");
            check({31'd0, irq_hi}, {31'd0, |(m_stat[31:16] & m_mask[31:16])}, "R10 irq_hi vs model");
            check({31'd0, irq_any}, {31'd0, |(m_stat & m_mask)}, "R10 irq_any vs model");
        end
    end

    task automatic bus_wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {idx, 2'b00}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] idx, input logic [31:0] m, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {idx, 2'b01};
        #(Q);
        check(bus_rdata & m, exp, tag);
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        summary();
        $finish;
    end

    initial begin
        // R1: reads during reset
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'(a << 2);
            #(Q);
            check(bus_rdata, 32'h0, "R1 register zero in reset");
        end
        check(pad_oe, 32'h0, "R1 pad_oe in reset");
        check({29'd0, irq_lo, irq_hi, irq_any}, 32'h0, "R1 irq in reset");
        @(negedge clk);
        bus_sel = 1'b0;
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R6: default low-level code with pads low sets every status bit
        idle(2);
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 low level after reset");
        check({31'd0, irq_any}, 32'h0, "R11 latched but masked");

        // R2
        bus_wr(A_DATA, 32'hA5A5_0F0F);
        bus_wr(A_DIR, 32'h0000_FFFF);
        #(Q);
        check(pad_out, 32'hA5A5_0F0F, "R2 pad_out");
        check(pad_oe, 32'h0000_FFFF, "R2 pad_oe");

        // R3: pad register ignores writes
        bus_wr(A_PAD, 32'hFFFF_FFFF);
        rd_chk(A_PAD, 32'hFFFF_FFFF, 32'h0, "R3 pad level read-only");

        // R4: level visible whatever the direction
        set_pad(32'h1234_5678);
        idle(1);
        rd_chk(A_PAD, 32'hFFFF_FFFF, 32'h1234_5678, "R4 synchronised pad level");

        bus_wr(A_LO, 32'hAAAA_AAAA);
        bus_wr(A_HI, 32'hAAAA_AAAA);
        rd_chk(A_LO, 32'hFFFF_FFFF, 32'hAAAA_AAAA, "R3 low code register");
        rd_chk(A_HI, 32'hFFFF_FFFF, 32'hAAAA_AAAA, "R3 high code register");
        set_pad(32'h0);
        idle(4);
        bus_wr(A_STAT, 32'hFFFF_FFFF);
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0, "R9 clear all");

        // R7: rising on pin 3 with exact latency
        set_pad(32'h0000_0008);
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0, "R7 not set after one edge");
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0, "R7 not set after two edges");
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0000_0008, "R7 rising set after three edges");
        set_pad(32'h0);
        idle(4);
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0000_0008, "R7 fall ignored under rising code");
        bus_wr(A_STAT, 32'h0);
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0000_0008, "R9 write zero no effect");
        bus_wr(A_STAT, 32'h0000_0008);
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0, "R9 write one clears");

        // R5/R7: falling code for pin 20 in the high register
        bus_wr(A_HI, 32'hAAAA_ABAA);
        set_pad(32'h0010_0000);
        idle(4);
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0, "R7 rise ignored under falling code");
        set_pad(32'h0);
        idle(4);
        rd_chk(A_STAT, 32'hFFFF_FFFF, 32'h0010_0000, "R5 falling code at pin 20");

        // R10
        check({29'd0, irq_lo, irq_hi, irq_any}, 32'h0, "R11 masked pending gives no irq");
        bus_wr(A_MASK, 32'h0010_0000);
        #(Q);
        check({29'd0, irq_lo, irq_hi, irq_any}, 32'h3, "R10 high-half irq");
        bus_wr(A_STAT, 32'h0010_0000);
        #(Q);
        check({29'd0, irq_lo, irq_hi, irq_any}, 32'h0, "R10 irq drops after clear");

        // R6: level high on pin 5
        bus_wr(A_LO, 32'hAAAA_A6AA);
        bus_wr(A_MASK, 32'h0000_0020);
        set_pad(32'h0000_0020);
        idle(4);
        bus_wr(A_STAT, 32'h0000_0020);
        rd_chk(A_STAT, 32'h0000_0020, 32'h0000_0020, "R6 clear lost while level holds");
        check({29'd0, irq_lo, irq_hi, irq_any}, 32'h5, "R10 low-half irq");
        set_pad(32'h0);
        idle(4);
        bus_wr(A_STAT, 32'h0000_0020);
        rd_chk(A_STAT, 32'h0000_0020, 32'h0, "R6 clear sticks once level gone");

        // R8: any-change on pin 7 with rising code
        bus_wr(A_ANY, 32'h0000_0080);
        rd_chk(A_ANY, 32'hFFFF_FFFF, 32'h0000_0080, "R3 any-change register");
        set_pad(32'h0000_0080);
        idle(4);
        rd_chk(A_STAT, 32'h0000_0080, 32'h0000_0080, "R8 rise flagged");
        bus_wr(A_STAT, 32'h0000_0080);
        set_pad(32'h0);
        idle(4);
        rd_chk(A_STAT, 32'h0000_0080, 32'h0000_0080, "R8 fall flagged despite rising code");

        // R8: any-change overrides low-level code on pin 1
        bus_wr(A_LO, 32'hAAAA_A6A2);
        idle(3);
        rd_chk(A_STAT, 32'h0000_0002, 32'h0000_0002, "R6 low level on pin 1");
        bus_wr(A_ANY, 32'h0000_0082);
        idle(2);
        bus_wr(A_STAT, 32'h0000_0002);
        idle(3);
        rd_chk(A_STAT, 32'h0000_0002, 32'h0, "R8 code ignored while steady");

        // R5: pin 16 uses bits 1:0 of the high register
        set_pad(32'h0001_0000);
        idle(4);
        rd_chk(A_STAT, 32'h0001_8000, 32'h0001_0000, "R5 pin 16 boundary");

        idle(3);
        summary();
        $finish;
    end

endmodule